// File: doc/BRIEF.md
# Positional cube operation unit

This unit works on product terms of functions with multi-valued inputs. Each term (a cube) is held as one bit vector made of one field per input variable. A field has as many bits as its variable has values, and bit j of a field is set when value j belongs to that variable's literal. A field with every bit set is a don't-care. A field with every bit clear is an empty literal, and a cube that contains one denotes the empty set.

Each request carries two operand cubes `a` and `b`, a 3-bit opcode and a field index. It returns a result cube, a one-bit flag and an integer size. The operations are:

- intersection and supercube, done bitwise;
- inversion of one selected literal;
- the size of a cube, which is the product of the set-bit counts of its fields;
- a test for whether two cubes merge exactly into one;
- a containment test.

Requests and results use a valid/ready handshake. One registered result is produced for each accepted request.

Top module: `pcube_alu`

## Requirements
- R1: While `rst_n` is low, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is high whenever no result is held or `rsp_ready` is high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears, with `rsp_valid` high, right after that edge. The result stays unchanged while `rsp_ready` is low. Results come out in request order, one per request.
- R3: Opcode 0 (intersect): `rsp_cube` = `a & b`. `rsp_flag` is 1 exactly when some field of the result is all zeros.
- R4: Opcode 1 (supercube): `rsp_cube` = `a | b`. `rsp_flag` is 1 exactly when every bit of the result is set, meaning every variable is a don't-care.
- R5: Opcode 2 (literal invert): the field chosen by `fsel` is inverted and every other field passes from `a` unchanged. An `fsel` of `NVAR` or more leaves `a` unchanged. `rsp_flag` is 1 when the result has an all-zero field.
- R6: Opcode 3 (size): `rsp_size` is the product, over all fields of `a`, of the number of set bits in each field. `rsp_cube` = `a`. `rsp_flag` is 1 when `a` has an empty field. A minterm gives 1. The all-ones cube gives the product of all radices, which is 30720 by default.
- R7: Opcode 4 (merge test): `rsp_flag` is 1 exactly when both operands have no empty field and they differ in exactly one field. Identical cubes give 0. `rsp_cube` = `a | b`.
- R8: Opcode 5 (containment): `rsp_cube` = `a & ~b`. `rsp_flag` is 1 exactly when that cube is all zeros, meaning `a` lies inside `b`.
- R9: Opcodes 6 and 7 return a zero cube, a zero flag and a zero size. `rsp_size` is 0 for every opcode other than 3.
- R10: Field 0 sits at the least significant bits and each later field sits directly above the previous one. With the default radices 2,3,4,5,2,4,4,8 the fields occupy bits [1:0], [4:2], [8:5], [13:9], [15:14], [19:16], [23:20] and [31:24].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| op | input | 3 | Opcode |
| fsel | input | clog2(NVAR+1) | Field index for literal invert |
| a | input | W | Operand cube A |
| b | input | W | Operand cube B |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_cube | output | W | Result cube |
| rsp_flag | output | 1 | Result flag, meaning set by the opcode |
| rsp_size | output | SZW | Cube size (opcode 3 only) |

## Verification
A wrong field boundary shows in the very next result, as a flag or size that mismatches only for some radices. Inverting a field at a shifted offset corrupts its neighbour, and a bad size product is off by a factor. A fault in the output register or handshake shows as a result that changes while it is stalled, or as a queue that ends out of step. Random back-pressure makes either fault show within a few requests.

// File: rtl/pcube_pkg.sv
`timescale 1ns/1ps
package pcube_pkg;
  localparam int MAXV = 32;

  typedef enum logic [2:0] {
    OP_AND    = 3'd0,
    OP_OR     = 3'd1,
    OP_LCOMP  = 3'd2,
    OP_SIZE   = 3'd3,
    OP_MERGE  = 3'd4,
    OP_INSIDE = 3'd5
  } cube_op_e;

  function automatic int radix_of(input logic [8*MAXV-1:0] r, input int i);
    return int'(r[8*i +: 8]);
  endfunction

  function automatic int field_base(input logic [8*MAXV-1:0] r, input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += radix_of(r, k);
    return s;
  endfunction

  function automatic longint radix_prod(input logic [8*MAXV-1:0] r, input int n);
    longint p = 1;
    for (int k = 0; k < n; k++) p *= longint'(radix_of(r, k));
    return p;
  endfunction
endpackage

// File: rtl/pcube_alu.sv
`timescale 1ns/1ps
module pcube_alu import pcube_pkg::*; #(
  parameter int NVAR = 8,
  parameter logic [8*NVAR-1:0] RADIX = {8'd8, 8'd4, 8'd4, 8'd2, 8'd5, 8'd4, 8'd3, 8'd2},
  localparam int W   = field_base((8*MAXV)'(RADIX), NVAR),
  localparam int SZW = $clog2(radix_prod((8*MAXV)'(RADIX), NVAR) + 1),
  localparam int FSW = $clog2(NVAR + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     op,
  input  logic [FSW-1:0] fsel,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [W-1:0]   rsp_cube,
  output logic           rsp_flag,
  output logic [SZW-1:0] rsp_size
);
  localparam logic [8*MAXV-1:0] RX = (8*MAXV)'(RADIX);

  function automatic logic [W-1:0] fmask(input int i);
    logic [W-1:0] m = '0;
    int lo = field_base(RX, i);
    int hi = lo + radix_of(RX, i);
    for (int k = 0; k < W; k++) m[k] = (k >= lo) && (k < hi);
    return m;
  endfunction

  function automatic logic has_empty(input logic [W-1:0] v);
    logic e = 1'b0;
    for (int i = 0; i < NVAR; i++) if ((v & fmask(i)) == '0) e = 1'b1;
    return e;
  endfunction

  function automatic logic [SZW-1:0] volume(input logic [W-1:0] v);
    logic [SZW-1:0] p = SZW'(1);
    for (int i = 0; i < NVAR; i++) p = p * SZW'($countones(v & fmask(i)));
    return p;
  endfunction

  function automatic int ndiff(input logic [W-1:0] x, input logic [W-1:0] y);
    int n = 0;
    for (int i = 0; i < NVAR; i++) if (((x ^ y) & fmask(i)) != '0) n++;
    return n;
  endfunction

  logic           accept;
  logic [W-1:0]   n_cube;
  logic           n_flag;
  logic [SZW-1:0] n_size;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    n_cube = '0;
    n_flag = 1'b0;
    n_size = '0;
    case (op)
      OP_AND: begin
        n_cube = a & b;
        n_flag = has_empty(a & b);
      end
      OP_OR: begin
        n_cube = a | b;
        n_flag = &(a | b);
      end
      OP_LCOMP: begin
        n_cube = (int'(fsel) < NVAR) ? (a ^ fmask(int'(fsel))) : a;
        n_flag = has_empty(n_cube);
      end
      OP_SIZE: begin
        n_cube = a;
        n_size = volume(a);
        n_flag = has_empty(a);
      end
      OP_MERGE: begin
        n_cube = a | b;
        n_flag = (ndiff(a, b) == 1) && !has_empty(a) && !has_empty(b);
      end
      OP_INSIDE: begin
        n_cube = a & ~b;
        n_flag = ((a & ~b) == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cube  <= '0;
      rsp_flag  <= 1'b0;
      rsp_size  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_cube  <= n_cube;
      rsp_flag  <= n_flag;
      rsp_size  <= n_size;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcube_alu_chk.sv
`timescale 1ns/1ps
module pcube_alu_chk import pcube_pkg::*; #(
  parameter int NVAR = 8,
  parameter logic [8*NVAR-1:0] RADIX = {8'd8, 8'd4, 8'd4, 8'd2, 8'd5, 8'd4, 8'd3, 8'd2},
  localparam int W   = field_base((8*MAXV)'(RADIX), NVAR),
  localparam int SZW = $clog2(radix_prod((8*MAXV)'(RADIX), NVAR) + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [2:0]     op,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [W-1:0]   rsp_cube,
  input logic           rsp_flag,
  input logic [SZW-1:0] rsp_size
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cube) && $stable(rsp_flag) && $stable(rsp_size)));

  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  a_r3_and_cube: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd0) |=> (rsp_cube == $past(a & b)));

  a_r4_or_cube: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd1) |=> (rsp_cube == $past(a | b)));

  a_r8_inside_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd5) |=> (rsp_flag == ($past(a & ~b) == '0)));

  a_r9_size_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op != 3'd3) |=> (rsp_size == '0));
endmodule

bind pcube_alu pcube_alu_chk #(.NVAR(NVAR), .RADIX(RADIX)) u_chk (.*);

// File: tb/pcube_alu_tb.sv
`timescale 1ns/1ps
module pcube_alu_tb;
  localparam int NV = 8;
  localparam int BR [NV] = '{2, 3, 4, 5, 2, 4, 4, 8};
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [31:0] cube;
    logic        flag;
    logic [14:0] size;
    logic [2:0]  op;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  op = '0;
  logic [3:0]  fsel = '0;
  logic [31:0] a = '0, b = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_cube;
  logic        rsp_flag;
  logic [14:0] rsp_size;

  int   checks = 0, errors = 0;
  bit   bp_en = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pcube_alu u_dut (.*);

  function automatic int bbase(input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += BR[k];
    return s;
  endfunction

  function automatic logic [31:0] bmask(input int i);
    logic [31:0] m = '0;
    for (int k = 0; k < BR[i]; k++) m[bbase(i) + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] lit(input int i, input logic [7:0] bits);
    return (32'(bits) << bbase(i)) & bmask(i);
  endfunction

  function automatic logic bempty(input logic [31:0] v);
    for (int i = 0; i < NV; i++) if ((v & bmask(i)) == 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int bvol(input logic [31:0] v);
    int p = 1;
    for (int i = 0; i < NV; i++) p *= $countones(v & bmask(i));
    return p;
  endfunction

  function automatic logic [31:0] minterm();
    logic [31:0] m = '0;
    for (int i = 0; i < NV; i++) m[bbase(i) + int'($urandom % BR[i])] = 1'b1;
    return m;
  endfunction

  function automatic string rtag(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] o, input logic [3:0] fs,
                                 input logic [31:0] x, input logic [31:0] y);
    exp_t e;
    int nd;
    e = '0;
    e.op = o;
    case (o)
      3'd0: begin e.cube = x & y; e.flag = bempty(x & y); end
      3'd1: begin e.cube = x | y; e.flag = ((x | y) == FULL); end
      3'd2: begin e.cube = (fs < 4'(NV)) ? (x ^ bmask(int'(fs))) : x; e.flag = bempty(e.cube); end
      3'd3: begin e.cube = x; e.size = 15'(bvol(x)); e.flag = bempty(x); end
      3'd4: begin
        nd = 0;
        for (int i = 0; i < NV; i++) if (((x ^ y) & bmask(i)) != 0) nd++;
        e.cube = x | y;
        e.flag = (nd == 1) && !bempty(x) && !bempty(y);
      end
      3'd5: begin e.cube = x & ~y; e.flag = ((x & ~y) == 0); end
      default: ;
    endcase
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [3:0] fs,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk); #1;
    req_valid = 1'b1; op = o; fsel = fs; a = x; b = y;
    while (!req_ready) begin @(negedge clk); #1; end
    q.push_back(model(o, fs, x, y));
    @(posedge clk); #0.2;
    req_valid = 1'b0;
    if (!bp_en) begin
      @(negedge clk); #1;
      chk(rsp_valid === 1'b1, "R2", "result one cycle after accept", 64'(rsp_valid), 64'd1);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "result with no request", 64'(rsp_cube), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_cube === e.cube, rtag(e.op), "cube", 64'(rsp_cube), 64'(e.cube));
          chk(rsp_flag === e.flag, rtag(e.op), "flag", 64'(rsp_flag), 64'(e.flag));
          chk(rsp_size === e.size, (e.op == 3'd3) ? "R6" : "R9", "size", 64'(rsp_size), 64'(e.size));
        end
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
    report();
  end

  initial begin
    logic [31:0] m1, m2, x;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(req_ready === 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // R3 intersect
    issue(3'd0, 4'd0, FULL, FULL);
    issue(3'd0, 4'd0, (FULL & ~bmask(2)) | lit(2, 8'h1), (FULL & ~bmask(2)) | lit(2, 8'h2));
    // R4 supercube
    issue(3'd1, 4'd0, (FULL & ~bmask(7)) | lit(7, 8'h0F), lit(7, 8'hF0));
    m1 = minterm(); m2 = minterm();
    issue(3'd1, 4'd0, m1, m2);
    // R5 literal invert, incl. out-of-range index
    issue(3'd2, 4'd3, FULL, 4'd0);
    issue(3'd2, 4'd1, m1, 0);
    issue(3'd2, 4'd9, m1, 0);
    // R10 explicit bit positions: invert field 3 (bits 13:9) of a cube whose field 3 is 5'b00101
    x = (FULL & ~32'h0000_3E00) | 32'h0000_0A00;
    issue(3'd2, 4'd3, x, 0);
    @(negedge clk); #1;
    chk(rsp_cube === ((FULL & ~32'h0000_3E00) | 32'h0000_3400), "R10", "field 3 at bits 13:9",
        64'(rsp_cube), 64'((FULL & ~32'h0000_3E00) | 32'h0000_3400));
    // R6 size
    issue(3'd3, 4'd0, m1, 0);
    issue(3'd3, 4'd0, FULL, 0);
    issue(3'd3, 4'd0, (FULL & ~bmask(3) & ~bmask(7)) | lit(3, 8'h13) | lit(7, 8'h5B), 0);
    issue(3'd3, 4'd0, FULL & ~bmask(5), 0);
    // R7 merge test
    x = (m1 & ~bmask(4)) | (~m1 & bmask(4));
    issue(3'd4, 4'd0, m1, x);
    issue(3'd4, 4'd0, m1, m1);
    issue(3'd4, 4'd0, m1, (x & ~bmask(0)) | (~m1 & bmask(0)));
    issue(3'd4, 4'd0, m1 & ~bmask(6), x & ~bmask(6));
    // R8 containment
    issue(3'd5, 4'd0, m1, FULL);
    issue(3'd5, 4'd0, FULL, m1);
    // R9 unused opcodes
    issue(3'd6, 4'd2, FULL, m1);
    issue(3'd7, 4'd5, m1, FULL);

    // random traffic under back-pressure (R2 ordering and hold)
    bp_en = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      for (int i = 0; i < NV; i++) if (($urandom % 6) == 0) ra = ra & ~bmask(i);
      if (($urandom % 3) == 0) begin
        int f = int'($urandom % NV);
        rb = (ra & ~bmask(f)) | ($urandom & bmask(f));
      end else begin
        rb = $urandom;
      end
      issue(3'($urandom % 8), 4'($urandom % 10), ra, rb);
    end
    bp_en = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(q.size() == 0, "R2", "outstanding results", 64'(q.size()), 64'd0);
    report();
  end
endmodule